// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

An eight-pin general-purpose I/O port that sits on a simple synchronous 8-bit processor bus. Software sees two byte registers: a port data latch and a direction register. Each direction bit turns the tri-state pad driver of its pin on (output) or off (input). The latch value goes straight to the pad outputs, and the direction bits go straight to the pad output-enables.

A read of the data register is resolved bit by bit. An output pin returns its latch bit. An input pin returns the level seen on the pad after a two-flop synchronizer. The latch accepts writes whatever the direction bits are. Software can therefore load the value it wants driven and only then turn the pin into an output, and the pad never shows a stale level. All bus reads are registered and arrive one clock after the request. Offsets that hold no register read as zero and ignore writes.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, every direction bit is 0 (all pins inputs, `pin_oe` = 0x00), the data latch is 0 (`pin_out` = 0x00) and `rdata` is 0x00.
- R2: A write (`cs`=1, `we`=1) to offset 0x04 loads `wdata` into the direction register, and `pin_oe` equals the new value from the cycle after the write edge. A direction bit of 1 makes its pin an output.
- R3: A read (`cs`=1, `we`=0) of offset 0x04 returns the last value written to the direction register.
- R4: A write to offset 0x00 loads `wdata` into the data latch whatever the direction bits are, and `pin_out` equals the latch from the cycle after the write edge.
- R5: A read of offset 0x00 returns, for each bit, the latch bit where the direction bit is 1 and the synchronized pin level where the direction bit is 0.
- R6: Pin levels pass through two synchronizer flops. The value that a read captures at clock edge e reflects `pin_in` as it was sampled at edge e-2.
- R7: `rdata` is registered: it shows the result of a read one clock after the request edge, and it is 0x00 in any cycle that follows an edge with no read.
- R8: A read of any offset other than 0x00 and 0x04 returns 0x00. A write to any such offset changes neither the latch nor the direction register.
- R9: A write to the direction register leaves the data latch, and therefore `pin_out`, unchanged. A pin that is switched to output drives its preloaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select for a bus access this cycle |
| we | input | 1 | 1 = write, 0 = read (valid while cs is 1) |
| addr | input | 8 | Byte offset within the port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Sampled pad levels (asynchronous) |
| pin_out | output | 8 | Pad output values (data latch) |
| pin_oe | output | 8 | Pad output-enables (direction register) |

## Verification
Register writes show on `pin_out` and `pin_oe` one clock after the write edge. Reads show on `rdata` one clock after the request edge. A pin change reaches read data only for a read captured two edges after the edge that first sampled the new level. The bench drives every input half a cycle after a rising edge and compares all three outputs against a behavioural model at each falling edge, so every result is sampled in the cycle it is due. Directed back-to-back reads across a pin change pin down the synchronizer delay exactly: the first two reads return the old level and the third returns the new one.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Shared types for the GPIO port: the register selected by a bus decode.
// Assumes only one register is selected at a time.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/gpio_port_sync.sv
// Module gpio_port_sync
// Brings asynchronous pad levels into the clock domain through a chain
// of STAGES flops per bit. Assumes each pin is independent (no bus
// coherency across bits is needed).
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pad sample along the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
// Module gpio_port_regs
// Holds the port data latch and the direction register. Both clear on
// reset. The latch accepts writes whatever the direction bits are.
// Assumes at most one write enable is high per cycle.
module gpio_port_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_latch,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);

    // Update the data latch on a data-offset write.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (wr_latch) latch_q <= wdata;
    end

    // Update the direction bits on a direction-offset write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // R4: a latch write lands on the next cycle.
    assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> latch_q == $past(wdata));

    // R2: a direction write lands on the next cycle.
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> dir_q == $past(wdata));

    // R9: switching direction never disturbs the latch.
    assert_dir_keeps_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir && !wr_latch) |=> $stable(latch_q));

endmodule

// File: rtl/gpio_port_rdmux.sv
// Module gpio_port_rdmux
// Registered read path. A data read merges latch bits (outputs) with
// synchronized pin bits (inputs). A direction read returns the direction
// register. Anything else, including no read, gives zero.
module gpio_port_rdmux #(
    parameter int WIDTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  gpio_port_pkg::reg_sel_e   sel,
    input  logic [WIDTH-1:0]          latch_q,
    input  logic [WIDTH-1:0]          dir_q,
    input  logic [WIDTH-1:0]          pins_sync,
    output logic [WIDTH-1:0]          rdata
);
    import gpio_port_pkg::*;

    logic [WIDTH-1:0] rd_next;
    logic [WIDTH-1:0] data_view;

    // Per-bit choice between the latch and the live pin.
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign data_view[b] = dir_q[b] ? latch_q[b] : pins_sync[b];
        end
    endgenerate

    // Pick the read value for the selected register.
    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            case (sel)
                SEL_DATA: rd_next = data_view;
                SEL_DIR:  rd_next = dir_q;
                default:  rd_next = '0;
            endcase
        end
    end

    // Register the read data for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

    // R7: no read means zero read data one cycle later.
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

    // R8: unused offsets read as zero.
    assert_unused_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> rdata == '0);

endmodule

// File: rtl/gpio_port.sv
// Module gpio_port
// Eight-pin bidirectional GPIO port on a synchronous byte bus. It decodes
// the data and direction offsets, drives the pad outputs and enables
// straight from the registers, and synchronizes the pad inputs for reads.
// Assumes the bus holds cs, we, addr and wdata stable around each edge.
module gpio_port #(
    parameter int          WIDTH    = 8,
    parameter int          AW       = 8,
    parameter int          SYNC_FF  = 2,
    parameter logic [7:0]  DATA_OFF = 8'h00,
    parameter logic [7:0]  DIR_OFF  = 8'h04
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    import gpio_port_pkg::*;

    reg_sel_e         sel;
    logic             wr_latch;
    logic             wr_dir;
    logic             rd_en;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pins_sync;

    // Decode the offset into a register select.
    always_comb begin
        if (addr == AW'(DATA_OFF))     sel = SEL_DATA;
        else if (addr == AW'(DIR_OFF)) sel = SEL_DIR;
        else                           sel = SEL_NONE;
    end

    assign wr_latch = cs && we && (sel == SEL_DATA);
    assign wr_dir   = cs && we && (sel == SEL_DIR);
    assign rd_en    = cs && !we;

    gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_FF)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_latch (wr_latch),
        .wr_dir   (wr_dir),
        .wdata    (wdata),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    gpio_port_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .sel       (sel),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pins_sync (pins_sync),
        .rdata     (rdata)
    );

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

    // R8: writes to unused offsets change no register.
    assert_unused_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && sel == SEL_NONE) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R3: a direction read returns the direction register.
    assert_dir_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_DIR) |=> rdata == $past(pin_oe));

    // R2: the output-enables change only after a direction write.
    assert_oe_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural model state.
    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_dir   = 8'h00;
    logic [7:0] m_rdata = 8'h00;
    logic [7:0] pin_hist [$];

    always #10 clk = ~clk;  // 50 MHz

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge, from the inputs held stable.
    always @(posedge clk) begin
        logic [7:0] old_pin;
        old_pin = (pin_hist.size() >= 2) ? pin_hist[0] : 8'h00;
        if (!rst_n) begin
            m_latch = 8'h00;
            m_dir   = 8'h00;
            m_rdata = 8'h00;
            pin_hist.delete();
            pin_hist.push_back(8'h00);
            pin_hist.push_back(8'h00);
        end else begin
            if (cs && !we) begin
                if (addr == 8'h00)      m_rdata = (m_latch & m_dir) | (old_pin & ~m_dir);
                else if (addr == 8'h04) m_rdata = m_dir;
                else                    m_rdata = 8'h00;
            end else begin
                m_rdata = 8'h00;
            end
            if (cs && we && addr == 8'h00) m_latch = wdata;
            if (cs && we && addr == 8'h04) m_dir   = wdata;
            void'(pin_hist.pop_front());
            pin_hist.push_back(pin_in);
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pin_out, m_latch, "R4 pin_out");
            check(pin_oe,  m_dir,   "R2 pin_oe");
            check(rdata,   m_rdata, "R5 rdata");
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        cs = 1'b0; we = 1'b0;
        step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        step();
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cs = 1'b1; we = 1'b0; addr = a;
        step();
        cs = 1'b0;
        check(rdata, exp, tag);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state.
        check(pin_oe, 8'h00, "R1 pin_oe after reset");
        check(pin_out, 8'h00, "R1 pin_out after reset");
        check(rdata, 8'h00, "R1 rdata after reset");
        rd(8'h04, 8'h00, "R1 direction reads zero");

        // R5: all inputs, read pins.
        pin_in = 8'h3C;
        repeat (3) idle();
        rd(8'h00, 8'h3C, "R5 all-input read returns pins");

        // R4: latch write while all inputs.
        wr(8'h00, 8'hA5);
        check(pin_out, 8'hA5, "R4 latch written while input");
        check(pin_oe, 8'h00, "R4 direction untouched");
        rd(8'h00, 8'h3C, "R5 inputs still read pins");

        // R2, R9, R3: switch upper nibble to output after preload.
        wr(8'h04, 8'hF0);
        check(pin_oe, 8'hF0, "R2 oe follows direction");
        check(pin_out, 8'hA5, "R9 preloaded value kept");
        rd(8'h04, 8'hF0, "R3 direction readback");
        rd(8'h00, 8'hAC, "R5 mixed read");

        // R8: unused offsets.
        wr(8'h08, 8'hFF);
        check(pin_out, 8'hA5, "R8 latch unchanged by unused write");
        check(pin_oe, 8'hF0, "R8 direction unchanged by unused write");
        rd(8'h08, 8'h00, "R8 unused read zero");
        rd(8'h01, 8'h00, "R8 unused read zero");

        // R6: synchronizer delay across a pin change.
        pin_in = 8'h03;
        rd(8'h00, 8'hAC, "R6 first read old level");
        rd(8'h00, 8'hAC, "R6 second read old level");
        rd(8'h00, 8'hA3, "R6 third read new level");

        // R7: idle after a read gives zero.
        idle();
        check(rdata, 8'h00, "R7 idle rdata zero");

        // R4, R5: all outputs, latch written while output.
        wr(8'h04, 8'hFF);
        rd(8'h00, 8'hA5, "R5 all-output read returns latch");
        wr(8'h00, 8'h5A);
        check(pin_out, 8'h5A, "R4 latch written while output");
        rd(8'h00, 8'h5A, "R5 all-output read new latch");

        // Random traffic, checked by the per-cycle model.
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            case ($urandom_range(0, 3))
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h08;
                default: a = 8'($urandom);
            endcase
            if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
            cs = ($urandom_range(0, 3) != 0);
            we = $urandom_range(0, 1) == 1;
            addr = a;
            wdata = 8'($urandom);
            step();
        end
        cs = 1'b0;
        repeat (3) step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule